// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

A legacy I/O configuration window built from an index/data port pair at two adjacent I/O addresses. After reset the window is locked. It opens only after a four-byte key has been written to the index port. The last key byte depends on which of the two supported index-port addresses the block is placed at. While the window is open, the host writes a register number to the index port and then reads or writes that register through the data port.

The register set holds a read-only chip identity, a logical-device selector and one global flash configuration register. That register carries the suspend flag, three enables for flash-mapped address segments, an enable for host writes to the serial flash, and a flash pin select. When the flash logical device is selected, two more registers hold the 16-bit I/O base address of the flash controller. These values drive the block's outputs, which feed the flash controller and the address decoder. Writing the exit code to the control register locks the window again. All configuration values are kept after the window locks.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked (`unlocked_o`=0). `suspend_o`, `seg_en_o`, `flash_wr_en_o` and `flash_pin_sel_o` are 0. `flash_base_o` equals parameter `BASE_RST`. The logical-device register is 0.
- R2: The window opens after the bytes 0x87, 0x01, 0x55 and a fourth key byte are written in order to the index port. The fourth byte is 0x55 when `INDEX_ADDR` is 0x2E and 0xAA when it is 0x4E. The data port is at `INDEX_ADDR`+1.
- R3: While the window is locked, an index-port byte that does not match the expected key byte returns the matcher to its first byte. A data-port write also returns it to the first byte.
- R4: While the window is locked, data-port reads return 0xFF and data-port writes change no register. Index-port reads always return 0xFF.
- R5: Register 0x20 reads `CHIP_ID[15:8]` and register 0x21 reads `CHIP_ID[7:0]`. Writes to either register are ignored.
- R6: Register 0x07 is the logical-device select. It is readable and writable as a full byte.
- R7: When register 0x07 holds 7, registers 0x64 and 0x65 read and write the high and low bytes of `flash_base_o`. When any other device is selected, writes to 0x64 and 0x65 are ignored and reads return 0x00.
- R8: In register 0x24, bit 0 drives `suspend_o`, bits 3:1 drive `seg_en_o[2:0]`, bit 4 drives `flash_wr_en_o` and bit 5 drives `flash_pin_sel_o`. Bits 7:6 read as 0.
- R9: Writing 0x02 to register 0x02 locks the window. Any other value written to 0x02 leaves it open. Configuration outputs keep their values after the window locks.
- R10: A data-port read returns its value on `io_rdata_o` in the cycle after the read strobe. A register write shows on the outputs in the cycle after the write strobe. Unimplemented registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | I/O write strobe, one cycle |
| io_rd_i | input | 1 | I/O read strobe, one cycle |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, registered |
| unlocked_o | output | 1 | Configuration window open |
| suspend_o | output | 1 | Suspend flag |
| seg_en_o | output | 3 | Flash-mapped address segment enables |
| flash_wr_en_o | output | 1 | Host write to serial flash allowed |
| flash_pin_sel_o | output | 1 | Flash signal pin select |
| flash_base_o | output | 16 | Flash controller I/O base address |

## Verification
Every result of this block is due exactly one clock edge after its strobe. A read strobe captures `io_rdata_o`, and a write strobe updates the matcher, the index and the configuration registers. The bench raises a strobe at a falling edge and drops it at the next falling edge. It samples `io_rdata_o` or the configuration outputs at that second falling edge, which is half a period after the edge that produced them. The same timing applies to the fourth key byte: `unlocked_o` is checked one cycle after that byte is written. A second instance placed at the other index address checks which fourth key byte each placement accepts.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] REG_CTL       = 8'h02;
  localparam logic [7:0] REG_LDN       = 8'h07;
  localparam logic [7:0] REG_ID_HI     = 8'h20;
  localparam logic [7:0] REG_ID_LO     = 8'h21;
  localparam logic [7:0] REG_FLASH_CFG = 8'h24;
  localparam logic [7:0] REG_BASE_HI   = 8'h64;
  localparam logic [7:0] REG_BASE_LO   = 8'h65;
  localparam logic [7:0] LDN_FLASH     = 8'h07;
  localparam logic [7:0] EXIT_CODE     = 8'h02;
  localparam int         KEY_LEN       = 4;

  typedef struct packed {
    logic       pin_sel;
    logic       wr_en;
    logic [2:0] seg_en;
    logic       suspend;
  } flash_cfg_t;

  function automatic logic [7:0] key_byte(input int pos, input logic [15:0] idx_addr);
    case (pos)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      2:       key_byte = 8'h55;
      default: key_byte = (idx_addr == 16'h004E) ? 8'hAA : 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] INDEX_ADDR = 16'h002E
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic       brk_i,
  input  logic [7:0] key_data_i,
  input  logic       exit_i,
  output logic       unlocked_o
);
  localparam int POS_W = $clog2(KEY_LEN);
  localparam logic [POS_W-1:0] LAST = POS_W'(KEY_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             open_q;
  logic [KEY_LEN-1:0] hit;

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign hit[g] = (key_data_i == key_byte(g, INDEX_ADDR));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      open_q <= 1'b0;
    end else if (open_q) begin
      if (exit_i) open_q <= 1'b0;
      pos_q <= '0;
    end else if (brk_i) begin
      pos_q <= '0;
    end else if (key_wr_i) begin
      if (!hit[pos_q]) begin
        pos_q <= '0;
      end else if (pos_q == LAST) begin
        pos_q  <= '0;
        open_q <= 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign unlocked_o = open_q;
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [15:0] BASE_RST = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rd_val_o,
  output logic        exit_o,
  output flash_cfg_t  flash_cfg_o,
  output logic [15:0] flash_base_o
);
  localparam int NB = 2;
  localparam logic [7:0] BASE_IDX [NB] = '{REG_BASE_LO, REG_BASE_HI};

  logic [7:0] ldn_q;
  flash_cfg_t cfg_q;
  logic [7:0] base_q [NB];
  logic       ldn_flash;

  assign ldn_flash = (ldn_q == LDN_FLASH);
  assign exit_o    = wr_i && (idx_i == REG_CTL) && (wdata_i == EXIT_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q <= '0;
      cfg_q <= '0;
    end else if (wr_i) begin
      if (idx_i == REG_LDN)       ldn_q <= wdata_i;
      if (idx_i == REG_FLASH_CFG) cfg_q <= flash_cfg_t'(wdata_i[5:0]);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   base_q[b] <= BASE_RST[8*b +: 8];
      else if (wr_i && ldn_flash && idx_i == BASE_IDX[b]) base_q[b] <= wdata_i;
    end
    assign flash_base_o[8*b +: 8] = base_q[b];
  end

  always_comb begin
    rd_val_o = 8'h00;
    case (idx_i)
      REG_LDN:       rd_val_o = ldn_q;
      REG_ID_HI:     rd_val_o = CHIP_ID[15:8];
      REG_ID_LO:     rd_val_o = CHIP_ID[7:0];
      REG_FLASH_CFG: rd_val_o = {2'b00, cfg_q};
      REG_BASE_HI:   rd_val_o = ldn_flash ? base_q[1] : 8'h00;
      REG_BASE_LO:   rd_val_o = ldn_flash ? base_q[0] : 8'h00;
      default:       rd_val_o = 8'h00;
    endcase
  end

  assign flash_cfg_o = cfg_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [15:0] BASE_RST   = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output logic        unlocked_o,
  output logic        suspend_o,
  output logic [2:0]  seg_en_o,
  output logic        flash_wr_en_o,
  output logic        flash_pin_sel_o,
  output logic [15:0] flash_base_o
);
  localparam logic [15:0] DATA_ADDR = INDEX_ADDR + 16'd1;

  logic       open;
  logic       hit_idx, hit_dat;
  logic [7:0] index_q, rdata_q, rd_val;
  logic       exit_req;
  flash_cfg_t cfg;

  assign hit_idx = (io_addr_i == INDEX_ADDR);
  assign hit_dat = (io_addr_i == DATA_ADDR);

  sio_key_match #(.INDEX_ADDR(INDEX_ADDR)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (io_wr_i && hit_idx),
    .brk_i      (io_wr_i && hit_dat),
    .key_data_i (io_wdata_i),
    .exit_i     (exit_req),
    .unlocked_o (open)
  );

  sio_cfg_regs #(.CHIP_ID(CHIP_ID), .BASE_RST(BASE_RST)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (io_wr_i && hit_dat && open),
    .idx_i        (index_q),
    .wdata_i      (io_wdata_i),
    .rd_val_o     (rd_val),
    .exit_o       (exit_req),
    .flash_cfg_o  (cfg),
    .flash_base_o (flash_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      rdata_q <= 8'hFF;
    end else begin
      if (io_wr_i && hit_idx && open) index_q <= io_wdata_i;
      if (io_rd_i) rdata_q <= (hit_dat && open) ? rd_val : 8'hFF;
    end
  end

  assign io_rdata_o      = rdata_q;
  assign unlocked_o      = open;
  assign suspend_o       = cfg.suspend;
  assign seg_en_o        = cfg.seg_en;
  assign flash_wr_en_o   = cfg.wr_en;
  assign flash_pin_sel_o = cfg.pin_sel;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [15:0] INDEX_ADDR = 16'h002E
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_wr_i,
  input logic        io_rd_i,
  input logic [15:0] io_addr_i,
  input logic [7:0]  io_wdata_i,
  input logic [7:0]  io_rdata_o,
  input logic        unlocked_o,
  input logic [15:0] flash_base_o,
  input logic [7:0]  idx_i
);
  localparam logic [15:0] DATA_ADDR = INDEX_ADDR + 16'd1;
  localparam logic [7:0]  KEY_LAST  = (INDEX_ADDR == 16'h004E) ? 8'hAA : 8'h55;

  // R2
  unlock_by_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(io_wr_i && io_addr_i == INDEX_ADDR && io_wdata_i == KEY_LAST));

  // R4
  locked_read_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && io_rd_i && io_addr_i == DATA_ADDR) |=> (io_rdata_o == 8'hFF));

  // R4
  locked_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && io_wr_i) |=> $stable(flash_base_o));

  // R9
  exit_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && io_wr_i && io_addr_i == DATA_ADDR && idx_i == 8'h02 && io_wdata_i == 8'h02)
      |=> !unlocked_o);

  // R7
  base_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flash_base_o) |-> $past(io_wr_i && unlocked_o && io_addr_i == DATA_ADDR));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.INDEX_ADDR(INDEX_ADDR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .io_wr_i      (io_wr_i),
  .io_rd_i      (io_rd_i),
  .io_addr_i    (io_addr_i),
  .io_wdata_i   (io_wdata_i),
  .io_rdata_o   (io_rdata_o),
  .unlocked_o   (unlocked_o),
  .flash_base_o (flash_base_o),
  .idx_i        (index_q)
);

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;
  localparam logic [1:0] W_IDX = 2'd0, W_DAT = 2'd1, R_DAT = 2'd2, R_IDX = 2'd3;
  localparam int NV = 31;
  // {op, data, expected read}
  localparam logic [17:0] VEC [NV] = '{
    {R_DAT, 8'h00, 8'hFF},  // R4 locked read
    {W_IDX, 8'h87, 8'h00}, {W_IDX, 8'h01, 8'h00},
    {W_IDX, 8'h55, 8'h00}, {W_IDX, 8'h55, 8'h00},  // R2 unlock
    {R_IDX, 8'h00, 8'hFF},  // R4 index read
    {W_IDX, 8'h20, 8'h00}, {R_DAT, 8'h00, 8'h87},  // R5
    {W_IDX, 8'h21, 8'h00}, {W_DAT, 8'h00, 8'h00}, {R_DAT, 8'h00, 8'h16},  // R5 ro
    {W_IDX, 8'h07, 8'h00}, {W_DAT, 8'h07, 8'h00}, {R_DAT, 8'h00, 8'h07},  // R6
    {W_IDX, 8'h64, 8'h00}, {W_DAT, 8'h12, 8'h00}, {R_DAT, 8'h00, 8'h12},  // R7
    {W_IDX, 8'h65, 8'h00}, {W_DAT, 8'h34, 8'h00}, {R_DAT, 8'h00, 8'h34},  // R7
    {W_IDX, 8'h24, 8'h00}, {W_DAT, 8'hFF, 8'h00}, {R_DAT, 8'h00, 8'h3F},  // R8
    {W_IDX, 8'h07, 8'h00}, {W_DAT, 8'h03, 8'h00},
    {W_IDX, 8'h64, 8'h00}, {W_DAT, 8'h99, 8'h00}, {R_DAT, 8'h00, 8'h00},  // R7 other ldn
    {W_IDX, 8'h30, 8'h00}, {R_DAT, 8'h00, 8'h00},  // R10 unimplemented
    {W_IDX, 8'h07, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_a, rdata_b;
  logic        unl_a, unl_b, susp, wr_en, pin_sel, susp_b, wr_en_b, pin_b;
  logic [2:0]  seg, seg_b;
  logic [15:0] base, base_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sio_cfg_port #(.INDEX_ADDR(16'h002E), .CHIP_ID(16'h8716), .BASE_RST(16'h0A00)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(wr), .io_rd_i(rd), .io_addr_i(addr),
    .io_wdata_i(wdata), .io_rdata_o(rdata_a), .unlocked_o(unl_a), .suspend_o(susp),
    .seg_en_o(seg), .flash_wr_en_o(wr_en), .flash_pin_sel_o(pin_sel), .flash_base_o(base));

  sio_cfg_port #(.INDEX_ADDR(16'h004E), .CHIP_ID(16'h8720), .BASE_RST(16'h0000)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(wr), .io_rd_i(rd), .io_addr_i(addr),
    .io_wdata_i(wdata), .io_rdata_o(rdata_b), .unlocked_o(unl_b), .suspend_o(susp_b),
    .seg_en_o(seg_b), .flash_wr_en_o(wr_en_b), .flash_pin_sel_o(pin_b), .flash_base_o(base_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // strobe for one cycle; results sampled one edge later
  task automatic io(input logic is_wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = is_wr; rd = !is_wr;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic key(input logic [15:0] a, input logic [7:0] k3, input logic [7:0] k4);
    io(1'b1, a, 8'h87); io(1'b1, a, 8'h01); io(1'b1, a, k3); io(1'b1, a, k4);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 unlocked", unl_a, 0);
    chk("R1 cfg", {susp, seg, wr_en, pin_sel}, 0);
    chk("R1 base", base, 16'h0A00);
    io(1'b1, 16'h002E, 8'h87); io(1'b1, 16'h002E, 8'h01);
    io(1'b1, 16'h002E, 8'h55); io(1'b1, 16'h002E, 8'h55);
    io(1'b1, 16'h002E, 8'h07); io(1'b0, 16'h002F, 8'h00);
    chk("R1 ldn", rdata_a, 8'h00);
    io(1'b1, 16'h002F, 8'h02);  // idx 07 -> ldn=2; restore below
    io(1'b1, 16'h002E, 8'h02); io(1'b1, 16'h002F, 8'h02);
    chk("R9 relock", unl_a, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] d, e;
      {op, d, e} = VEC[i];
      case (op)
        W_IDX: io(1'b1, 16'h002E, d);
        W_DAT: io(1'b1, 16'h002F, d);
        R_DAT: begin io(1'b0, 16'h002F, 8'h00); chk($sformatf("R10 vec%0d", i), rdata_a, e); end
        default: begin io(1'b0, 16'h002E, 8'h00); chk($sformatf("R4 vec%0d", i), rdata_a, e); end
      endcase
    end

    // R8 output mapping and R7 base outputs
    chk("R8 cfg outputs", {pin_sel, wr_en, seg, susp}, 6'h3F);
    chk("R7 base output", base, 16'h1234);
    io(1'b1, 16'h002F, 8'h07);
    io(1'b1, 16'h002E, 8'h24); io(1'b1, 16'h002F, 8'h2A);
    chk("R8 partial", {pin_sel, wr_en, seg, susp}, 6'h2A);
    // R9 non-exit value keeps window open
    io(1'b1, 16'h002E, 8'h02); io(1'b1, 16'h002F, 8'h01);
    chk("R9 other value", unl_a, 1);
    io(1'b1, 16'h002F, 8'h02);
    chk("R9 exit", unl_a, 0);
    chk("R9 retained", {base, 2'b00, pin_sel, wr_en, seg, susp}, {16'h1234, 8'h2A});
    // R4 locked write ignored
    io(1'b1, 16'h002F, 8'h00);
    chk("R4 locked write", {base, 2'b00, pin_sel, wr_en, seg, susp}, {16'h1234, 8'h2A});
    // R3 broken sequence
    io(1'b1, 16'h002E, 8'h87); io(1'b1, 16'h002E, 8'h01); io(1'b1, 16'h002E, 8'h00);
    io(1'b1, 16'h002E, 8'h55); io(1'b1, 16'h002E, 8'h55);
    chk("R3 mismatch", unl_a, 0);
    io(1'b1, 16'h002E, 8'h87); io(1'b1, 16'h002E, 8'h01); io(1'b1, 16'h002F, 8'h55);
    io(1'b1, 16'h002E, 8'h55); io(1'b1, 16'h002E, 8'h55);
    chk("R3 data write breaks", unl_a, 0);
    key(16'h002E, 8'h55, 8'h55);
    chk("R3 restart unlocks", unl_a, 1);
    // R2 alternate index address
    key(16'h004E, 8'h55, 8'h55);
    chk("R2 alt wrong key", unl_b, 0);
    key(16'h004E, 8'h55, 8'hAA);
    chk("R2 alt key", unl_b, 1);
    io(1'b1, 16'h004E, 8'h20); io(1'b0, 16'h004F, 8'h00);
    chk("R5 alt id", rdata_b, 8'h87);
    chk("R1 alt untouched", {base_b, susp_b, seg_b, wr_en_b, pin_b}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule